// File: doc/BRIEF.md
# Filtered Event Channel

This block is one routing channel of an on-chip event network. A source-select input picks one raw event line, together with its small data field, from a bank of sources. The picked line is captured on the next rising clock edge. It can then pass through a persistence filter, and it is handed to the consuming peripherals one cycle later. The output is a one-bit strobe and a two-bit data field. The data field is zero whenever the strobe is low.

Sources come in two kinds. Pulse sources raise their line for one cycle per event. Level sources keep it raised for as long as their condition lasts. The channel treats every cycle alike, so a level source produces one output strobe per cycle that it stays asserted. The persistence filter is intended mainly for pin-change sources. When it is enabled, a new input value replaces the last accepted one only after the same value has been seen on a configured number of back-to-back cycles. Shorter pulses and short glitches are dropped. Configuration arrives on plain ports.

Top module: `evt_channel`

## Requirements
- R1: A synchronous reset clears the capture, filter and output registers; in the cycle after a reset edge the strobe and the data field are 0, whatever the sources are doing.
- R2: Only the source whose index equals `src_sel` affects the outputs; activity on every other source line and data field is ignored.
- R3: With the filter inactive, a source value present before rising edge e appears on the strobe after edge e+1 (two cycles of latency), and the same holds for the falling side.
- R4: With the filter inactive, a one-cycle input pulse yields exactly one strobe cycle, and an input held high for w cycles yields exactly w consecutive strobe cycles.
- R5: With `filt_en`=1 and `filt_len` code c, the required agreement count is L=c+1 (1 to 8). A new value is accepted only once L consecutive captured samples equal it, and the strobe then follows L-1 cycles later than it would without the filter, on both edges, so a held input of w>=L cycles still yields w strobe cycles.
- R6: With the filter active, an input pulse shorter than L cycles produces no strobe, and a low glitch shorter than L cycles inside a held-high input leaves the strobe high throughout.
- R7: `filt_len` code 0 with `filt_en`=1 behaves exactly like `filt_en`=0, and with `filt_en`=0 the value of `filt_len` has no effect.
- R8: When the strobe is high, `evt_data` equals the 2-bit data field of the selected source (source i occupies `src_data[2i+1:2i]`), captured in the same pipeline cycle as the event; when the strobe is low, `evt_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | SEL_W (3) | Index of the routed source |
| src_evt | input | NUM_SRC (8) | Raw event lines, one per source |
| src_data | input | NUM_SRC*DATA_W (16) | Data fields, source i at bits [DATA_W*i +: DATA_W] |
| filt_en | input | 1 | Enables the persistence filter |
| filt_len | input | LEN_W (3) | Filter length code; agreement count is code+1 |
| evt_out | output | 1 | Event strobe to users |
| evt_data | output | DATA_W (2) | Event data to users, zero when the strobe is low |

## Verification
The bench builds the channel with its defaults: eight sources, a 2-bit data field and a 3-bit length code. With these values every agreement count from 1 to 8 can be set, and the sweep can cover all of them. Pulse widths run from 1 to 9 cycles, so for each length the sweep crosses the point where a pulse is one cycle too short to pass and the point where it just passes. The routed source rotates across all eight indices while the others toggle, so every select value is exercised against live neighbours.

// File: rtl/evt_channel.sv
module evt_channel #(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 2,
  parameter int LEN_W   = 3,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SEL_W-1:0]            src_sel,
  input  logic [NUM_SRC-1:0]          src_evt,
  input  logic [NUM_SRC*DATA_W-1:0]   src_data,
  input  logic                        filt_en,
  input  logic [LEN_W-1:0]            filt_len,
  output logic                        evt_out,
  output logic [DATA_W-1:0]           evt_data
);

  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(1 << LEN_W);

  logic              cap_evt;
  logic [DATA_W-1:0] cap_dat;
  logic              prev_smp;
  logic [CNT_W-1:0]  run;
  logic              acc;

  wire              pick_evt = src_evt[src_sel];
  wire [DATA_W-1:0] pick_dat = src_data[src_sel*DATA_W +: DATA_W];

  wire              flt_on = filt_en && (filt_len != '0);
  wire [CNT_W-1:0]  need   = {1'b0, filt_len} + CNT_W'(1);

  wire [CNT_W-1:0]  run_nxt = (cap_evt != prev_smp) ? CNT_W'(1) :
                              (run == RUN_MAX)      ? run : run + CNT_W'(1);

  wire              filt_val = !flt_on           ? cap_evt :
                               (run_nxt >= need) ? cap_evt : acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_evt  <= 1'b0;
      cap_dat  <= '0;
      prev_smp <= 1'b0;
      run      <= '0;
      acc      <= 1'b0;
      evt_out  <= 1'b0;
      evt_data <= '0;
    end else begin
      cap_evt  <= pick_evt;
      cap_dat  <= pick_dat;
      prev_smp <= cap_evt;
      run      <= run_nxt;
      acc      <= filt_val;
      evt_out  <= filt_val;
      evt_data <= filt_val ? cap_dat : '0;
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)              age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!evt_out && evt_data == '0));

  assert_data_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !evt_out |-> evt_data == '0);

  assert_two_cycle_path_R3: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && !$past(flt_on)) |-> evt_out == $past(src_evt[src_sel], 2));

  assert_filter_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(flt_on) && evt_out != $past(evt_out))
      |-> $past(run_nxt >= need));

endmodule

// File: tb/sim_evt_channel.sv
module sim_evt_channel;
  localparam int NS = 8;
  localparam int DW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    src_sel;
  logic [NS-1:0] src_evt;
  logic [NS*DW-1:0] src_data;
  logic          filt_en;
  logic [2:0]    filt_len;
  logic          evt_out;
  logic [DW-1:0] evt_data;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  evt_channel u0 (
    .clk(clk), .rst(rst), .src_sel(src_sel), .src_evt(src_evt),
    .src_data(src_data), .filt_en(filt_en), .filt_len(filt_len),
    .evt_out(evt_out), .evt_data(evt_data)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic e_evt, input logic [DW-1:0] e_dat);
    tests++;
    if (evt_out !== e_evt || evt_data !== e_dat) begin
      fails++;
      $display("FAIL %s: got evt=%b data=%0d, expected evt=%b data=%0d at %0t",
               req, evt_out, evt_data, e_evt, e_dat, $time);
    end
  endtask

  task automatic fill_data(input int seed);
    for (int i = 0; i < NS; i++) src_data[i*DW +: DW] = DW'((i + seed) % 4);
  endtask

  // R3 R4 R5 R6 R7 R8 R2: pulse of width w on source s, others toggling
  task automatic pulse_case(input bit en, input int code, input int w, input int s, input string req);
    int L;
    logic [DW-1:0] d;
    logic [NS-1:0] mask;
    L = en ? code + 1 : 1;
    filt_en = en; filt_len = 3'(code); src_sel = 3'(s);
    fill_data(w + code);
    d = src_data[s*DW +: DW];
    mask = NS'(1) << s;
    src_evt = '0;
    repeat (12) step();
    src_evt = mask;
    for (int k = 0; k < w + L + 3; k++) begin
      logic e;
      step();
      e = (w >= L) && (k >= L) && (k <= w + L - 1);
      chk(req, e, e ? d : '0);
      src_evt = ((k % 2) ? ~mask : '0) | ((k < w - 1) ? mask : '0);
    end
    src_evt = '0;
  endtask

  initial begin
    rst = 1'b1; src_sel = '0; src_evt = '0; src_data = '0;
    filt_en = 1'b0; filt_len = '0;
    repeat (3) step();
    rst = 1'b0;

    // R1: reset with an active source
    src_evt = '1; fill_data(1);
    repeat (4) step();
    rst = 1'b1;
    step();
    chk("R1", 1'b0, '0);
    step();
    chk("R1", 1'b0, '0);
    rst = 1'b0;
    src_evt = '0;
    repeat (4) step();

    // R2: unselected sources held high do not reach the output
    for (int s = 0; s < NS; s++) begin
      src_sel = 3'(s);
      src_evt = ~(NS'(1) << s);
      repeat (4) step();
      chk("R2", 1'b0, '0);
    end
    src_evt = '0;

    // R3 R4 R8 filter off; R7 with a nonzero code ignored
    for (int w = 1; w <= 9; w++) pulse_case(1'b0, 5, w, w % NS, "R3/R4/R7/R8");
    // R7: code 0 with filter enabled
    for (int w = 1; w <= 4; w++) pulse_case(1'b1, 0, w, (w + 3) % NS, "R7");
    // R5 R6: every length against widths around it
    for (int c = 1; c < 8; c++)
      for (int w = 1; w <= 9; w++)
        pulse_case(1'b1, c, w, (w + c) % NS, (w >= c + 1) ? "R5" : "R6");

    // R6: short low glitches inside a held level, L = 4
    filt_en = 1'b1; filt_len = 3'd3; src_sel = 3'd2; fill_data(0);
    for (int g = 1; g <= 3; g++) begin
      src_evt = 8'h04;
      repeat (12) step();
      chk("R6", 1'b1, src_data[2*DW +: DW]);
      src_evt = '0;
      repeat (g) step();
      src_evt = 8'h04;
      for (int k = 0; k < 8; k++) begin
        step();
        chk("R6", 1'b1, src_data[2*DW +: DW]);
      end
    end
    src_evt = '0;
    repeat (10) step();
    chk("R6", 1'b0, '0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got running, expected finished");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule